// File: doc/BRIEF.md
# Prefetch Usefulness and Accuracy Monitor

This block watches the traffic of a set-associative cache and judges whether each prefetch was worth issuing. For every line of the tag store it keeps one bit that marks a line brought in by the prefetcher and not yet touched by a demand access. Fill, demand-hit, eviction and demand-miss events arrive as one-cycle pulses, each carrying the set and way it concerns. From these pulses the block counts useful prefetches, useless prefetches and demand misses.

A window-end pulse closes the measurement interval. The three counts are latched onto the outputs and the live counters restart at zero. Two bit-serial dividers then produce a Q0.8 accuracy figure and a Q0.8 coverage figure, and a done strobe marks the moment both are valid.

The accuracy figure has useful + useless as its denominator. Prefetched lines that are still waiting for an outcome are left out of it. A line's bit survives window boundaries, so an outcome is credited to the window in which it is decided.

Top module: `pf_acc_mon`

## Requirements
- R1: A fill with `fill_pf`=1 marks the addressed line (set, way). The first demand hit to a marked line unmarks it and adds one to the useful count.
- R2: A demand fill (`fill_pf`=0) unmarks the addressed line. A demand hit to an unmarked line changes no count.
- R3: Evicting a marked line adds one to the useless count. Evicting an unmarked line changes no count.
- R4: Each window-end pulse produces `rpt_done` high for exactly one cycle, on the 8th rising edge after the edge that samples `win_end`. At that point `acc_q8` = min(255, floor(256·U/(U+L))), where U is the useful count and L is the useless count of the closed window.
- R5: When U+L = 0, `acc_q8` is 0 and `acc_undef` is 1. Otherwise `acc_undef` is 0.
- R6: `cov_q8` = min(255, floor(256·U/M)), where M is the demand-miss count of the closed window. When M = 0, `cov_q8` is 0 and `cov_undef` is 1.
- R7: Every counter is CW (16) bits wide and saturates at 65535.
- R8: A window-end pulse latches the closed window's counts onto `useful_o`, `useless_o` and `miss_o`, and the live counters restart at zero. Events in the same cycle as `win_end` belong to the closing window. Line marks persist across windows.
- R9: A demand hit and an eviction to the same line in the same cycle count as one useful prefetch and no useless prefetch.
- R10: Reset clears all line marks, all counters and all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fill_vld | input | 1 | Line fill event |
| fill_set | input | 4 | Set of the filled line |
| fill_way | input | 2 | Way of the filled line |
| fill_pf | input | 1 | 1 = fill caused by a prefetch, 0 = demand fill |
| hit_vld | input | 1 | Demand hit event |
| hit_set | input | 4 | Set of the hit line |
| hit_way | input | 2 | Way of the hit line |
| evict_vld | input | 1 | Eviction event |
| evict_set | input | 4 | Set of the evicted line |
| evict_way | input | 2 | Way of the evicted line |
| miss_vld | input | 1 | Demand miss event |
| win_end | input | 1 | Closes the measurement window |
| useful_o | output | 16 | Useful count of the last closed window |
| useless_o | output | 16 | Useless count of the last closed window |
| miss_o | output | 16 | Demand-miss count of the last closed window |
| rpt_done | output | 1 | One-cycle strobe: ratios valid |
| acc_q8 | output | 8 | Accuracy, Q0.8 |
| acc_undef | output | 1 | Accuracy denominator was zero |
| cov_q8 | output | 8 | Coverage, Q0.8 |
| cov_undef | output | 1 | Miss count was zero |

## Verification
The assertions check several rules on every cycle:
- the done strobe lasts a single cycle;
- an undefined accuracy reads as zero;
- a window with useful outcomes but no useless ones reports 255;
- the useful and useless counters never step by more than one between windows, and both read zero just after a window closes.

Other behaviour shows only through the bench's event sequences:
- the rules that decide whether a hit or an eviction counts, including the same-cycle case and a demand fill that unmarks a line;
- the crediting of an outcome to a later window;
- saturation after many thousands of misses;
- exact quotient values.

// File: rtl/pf_acc_mon.sv
module pf_acc_mon #(
  parameter int SETS = 16,
  parameter int WAYS = 4,
  parameter int CW   = 16,
  parameter int QW   = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    fill_vld,
  input  logic [$clog2(SETS)-1:0] fill_set,
  input  logic [$clog2(WAYS)-1:0] fill_way,
  input  logic                    fill_pf,
  input  logic                    hit_vld,
  input  logic [$clog2(SETS)-1:0] hit_set,
  input  logic [$clog2(WAYS)-1:0] hit_way,
  input  logic                    evict_vld,
  input  logic [$clog2(SETS)-1:0] evict_set,
  input  logic [$clog2(WAYS)-1:0] evict_way,
  input  logic                    miss_vld,
  input  logic                    win_end,
  output logic [CW-1:0]           useful_o,
  output logic [CW-1:0]           useless_o,
  output logic [CW-1:0]           miss_o,
  output logic                    rpt_done,
  output logic [QW-1:0]           acc_q8,
  output logic                    acc_undef,
  output logic [QW-1:0]           cov_q8,
  output logic                    cov_undef
);
  localparam int SW    = $clog2(SETS);
  localparam int WW    = $clog2(WAYS);
  localparam int LW    = SW + WW;
  localparam int LINES = SETS * WAYS;
  localparam int DW    = CW + 1;
  localparam int RW    = CW + 3;
  localparam int STW   = $clog2(QW + 1);

  // line index is {set, way}; SETS and WAYS are powers of two
  logic [LINES-1:0] mark;
  wire [LW-1:0] f_idx = {fill_set, fill_way};
  wire [LW-1:0] h_idx = {hit_set, hit_way};
  wire [LW-1:0] e_idx = {evict_set, evict_way};

  wire use_inc = hit_vld && mark[h_idx];
  wire usl_inc = evict_vld && mark[e_idx] && !(hit_vld && h_idx == e_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mark <= '0;
    else begin
      for (int i = 0; i < LINES; i++) begin
        if (fill_vld && f_idx == LW'(i))
          mark[i] <= fill_pf;
        else if ((hit_vld && h_idx == LW'(i)) || (evict_vld && e_idx == LW'(i)))
          mark[i] <= 1'b0;
      end
    end
  end

  function automatic logic [CW-1:0] bump(input logic [CW-1:0] c, input logic inc);
    return (inc && c != '1) ? c + 1'b1 : c;
  endfunction

  logic [CW-1:0] cnt_use, cnt_usl, cnt_miss;
  wire [CW-1:0] s_use  = bump(cnt_use, use_inc);
  wire [CW-1:0] s_usl  = bump(cnt_usl, usl_inc);
  wire [CW-1:0] s_miss = bump(cnt_miss, miss_vld);
  wire [DW-1:0] s_den  = DW'(s_use) + DW'(s_usl);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_use <= '0; cnt_usl <= '0; cnt_miss <= '0;
      useful_o <= '0; useless_o <= '0; miss_o <= '0;
    end else if (win_end) begin
      cnt_use <= '0; cnt_usl <= '0; cnt_miss <= '0;
      useful_o <= s_use; useless_o <= s_usl; miss_o <= s_miss;
    end else begin
      cnt_use <= s_use; cnt_usl <= s_usl; cnt_miss <= s_miss;
    end
  end

  // two restoring dividers, one quotient bit per cycle
  logic [RW-1:0]  ra, rc;
  logic [DW-1:0]  da;
  logic [CW-1:0]  dc;
  logic [QW-1:0]  qa, qc;
  logic           sa, sc, ua, uc, busy;
  logic [STW-1:0] steps;

  wire [RW-1:0] ra_sh = ra << 1;
  wire [RW-1:0] rc_sh = rc << 1;
  wire          ga    = ra_sh >= RW'(da);
  wire          gc    = rc_sh >= RW'(dc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ra <= '0; rc <= '0; da <= '0; dc <= '0; qa <= '0; qc <= '0;
      sa <= 1'b0; sc <= 1'b0; ua <= 1'b0; uc <= 1'b0;
      busy <= 1'b0; steps <= '0;
      rpt_done <= 1'b0; acc_q8 <= '0; acc_undef <= 1'b0;
      cov_q8 <= '0; cov_undef <= 1'b0;
    end else begin
      rpt_done <= 1'b0;
      if (win_end) begin
        ra <= RW'(s_use); da <= s_den;
        ua <= s_den == '0;
        sa <= s_usl == '0 && s_use != '0;
        rc <= RW'(s_use); dc <= s_miss;
        uc <= s_miss == '0;
        sc <= s_miss != '0 && s_use >= s_miss;
        qa <= '0; qc <= '0;
        busy <= 1'b1;
        steps <= STW'(QW);
      end else if (busy) begin
        ra <= ga ? ra_sh - RW'(da) : ra_sh;
        rc <= gc ? rc_sh - RW'(dc) : rc_sh;
        qa <= {qa[QW-2:0], ga};
        qc <= {qc[QW-2:0], gc};
        steps <= steps - 1'b1;
        if (steps == STW'(1)) begin
          busy      <= 1'b0;
          rpt_done  <= 1'b1;
          acc_undef <= ua;
          cov_undef <= uc;
          acc_q8    <= ua ? '0 : sa ? '1 : {qa[QW-2:0], ga};
          cov_q8    <= uc ? '0 : sc ? '1 : {qc[QW-2:0], gc};
        end
      end
    end
  end
endmodule

// File: rtl/pf_acc_mon_chk.sv
module pf_acc_mon_chk #(
  parameter int CW = 16,
  parameter int QW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          win_end,
  input logic          rpt_done,
  input logic          acc_undef,
  input logic [QW-1:0] acc_q8,
  input logic [CW-1:0] useful_o,
  input logic [CW-1:0] useless_o,
  input logic [CW-1:0] cnt_use,
  input logic [CW-1:0] cnt_usl
);
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_done |=> !rpt_done); // R4

  AST_ALL_USEFUL_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_done && !acc_undef && useful_o != '0 && useless_o == '0 |-> acc_q8 == '1); // R4

  AST_UNDEF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_done && acc_undef |-> acc_q8 == '0); // R5

  AST_WIN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    win_end |=> cnt_use == '0 && cnt_usl == '0); // R8

  AST_USEFUL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !win_end |=> (cnt_use == $past(cnt_use) || 32'(cnt_use) == 32'($past(cnt_use)) + 1)); // R1

  AST_USELESS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !win_end |=> (cnt_usl == $past(cnt_usl) || 32'(cnt_usl) == 32'($past(cnt_usl)) + 1)); // R3
endmodule

bind pf_acc_mon pf_acc_mon_chk #(.CW(CW), .QW(QW)) u_chk (
  .clk(clk), .rst_n(rst_n), .win_end(win_end), .rpt_done(rpt_done),
  .acc_undef(acc_undef), .acc_q8(acc_q8), .useful_o(useful_o),
  .useless_o(useless_o), .cnt_use(cnt_use), .cnt_usl(cnt_usl)
);

// File: tb/pf_acc_mon_test.sv
module pf_acc_mon_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 19;
  // {op[10:9], set[8:5], way[4:3], pf[2], useful+[1], useless+[0]}; op 0 fill, 1 hit, 2 evict, 3 miss
  localparam logic [10:0] VEC [NV] = '{
    {2'd0, 4'd1, 2'd0, 1'b1, 1'b0, 1'b0},
    {2'd0, 4'd2, 2'd1, 1'b1, 1'b0, 1'b0},
    {2'd0, 4'd3, 2'd2, 1'b1, 1'b0, 1'b0},
    {2'd0, 4'd4, 2'd3, 1'b0, 1'b0, 1'b0},
    {2'd1, 4'd1, 2'd0, 1'b0, 1'b1, 1'b0},
    {2'd1, 4'd1, 2'd0, 1'b0, 1'b0, 1'b0},
    {2'd2, 4'd2, 2'd1, 1'b0, 1'b0, 1'b1},
    {2'd2, 4'd4, 2'd3, 1'b0, 1'b0, 1'b0},
    {2'd0, 4'd5, 2'd0, 1'b1, 1'b0, 1'b0},
    {2'd0, 4'd5, 2'd0, 1'b0, 1'b0, 1'b0},
    {2'd1, 4'd5, 2'd0, 1'b0, 1'b0, 1'b0},
    {2'd2, 4'd5, 2'd0, 1'b0, 1'b0, 1'b0},
    {2'd3, 4'd0, 2'd0, 1'b0, 1'b0, 1'b0},
    {2'd3, 4'd0, 2'd0, 1'b0, 1'b0, 1'b0},
    {2'd3, 4'd0, 2'd0, 1'b0, 1'b0, 1'b0},
    {2'd0, 4'd6, 2'd1, 1'b1, 1'b0, 1'b0},
    {2'd1, 4'd6, 2'd1, 1'b0, 1'b1, 1'b0},
    {2'd0, 4'd7, 2'd3, 1'b1, 1'b0, 1'b0},
    {2'd2, 4'd7, 2'd3, 1'b0, 1'b0, 1'b1}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic fill_vld = 0, fill_pf = 0, hit_vld = 0, evict_vld = 0, miss_vld = 0, win_end = 0;
  logic [3:0] fill_set = 0, hit_set = 0, evict_set = 0;
  logic [1:0] fill_way = 0, hit_way = 0, evict_way = 0;
  logic [15:0] useful_o, useless_o, miss_o;
  logic rpt_done, acc_undef, cov_undef;
  logic [7:0] acc_q8, cov_q8;
  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pf_acc_mon uut (.*);

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int frac(int n, int d);
    if (d == 0) return 0;
    if (n >= d) return 255;
    return (n * 256) / d;
  endfunction

  task automatic clear_in();
    fill_vld = 0; hit_vld = 0; evict_vld = 0; miss_vld = 0; win_end = 0;
  endtask

  task automatic ev(int op, int s, int w, bit pf);
    @(negedge clk);
    clear_in();
    case (op)
      0: begin fill_vld = 1; fill_set = 4'(s); fill_way = 2'(w); fill_pf = pf; end
      1: begin hit_vld = 1; hit_set = 4'(s); hit_way = 2'(w); end
      2: begin evict_vld = 1; evict_set = 4'(s); evict_way = 2'(w); end
      default: miss_vld = 1;
    endcase
    @(negedge clk);
    clear_in();
  endtask

  // caller may pre-drive events for the window-end cycle
  task automatic close_win(string tag, int eu, int el, int em);
    int lat;
    win_end = 1;
    @(negedge clk);
    clear_in();
    lat = 1;
    while (!rpt_done && lat < 20) begin @(negedge clk); lat++; end
    check({tag, " R4 done latency"}, lat, 9);
    check({tag, " R8 useful count"}, useful_o, eu);
    check({tag, " R8 useless count"}, useless_o, el);
    check({tag, " R8 miss count"}, miss_o, em);
    check({tag, " R4 accuracy"}, acc_q8, frac(eu, eu + el));
    check({tag, " R5 acc undefined"}, acc_undef, (eu + el) == 0);
    check({tag, " R6 coverage"}, cov_q8, frac(eu, em));
    check({tag, " R6 cov undefined"}, cov_undef, em == 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int eu, el, em;
    repeat (3) @(negedge clk);
    check("R10 reset useful", useful_o, 0);
    check("R10 reset acc", acc_q8, 0);
    check("R10 reset done", rpt_done, 0);
    rst_n = 1;
    @(negedge clk);

    // R1 R2 R3: vector table
    eu = 0; el = 0; em = 0;
    for (int i = 0; i < NV; i++) begin
      ev(int'(VEC[i][10:9]), int'(VEC[i][8:5]), int'(VEC[i][4:3]), VEC[i][2]);
      eu += VEC[i][1]; el += VEC[i][0]; em += (VEC[i][10:9] == 2'd3);
    end
    @(negedge clk);
    close_win("table R1 R2 R3", eu, el, em);

    // R8: pending line (3,2) resolved in next window
    ev(1, 3, 2, 0);
    @(negedge clk);
    close_win("carry R8", 1, 0, 0);

    // R5: empty window
    @(negedge clk);
    close_win("empty R5", 0, 0, 0);

    // R9 and R8: same-cycle hit+evict, then evict in the window-end cycle
    ev(0, 8, 0, 1);
    @(negedge clk);
    hit_vld = 1; hit_set = 8; hit_way = 0;
    evict_vld = 1; evict_set = 8; evict_way = 0;
    @(negedge clk);
    clear_in();
    ev(0, 9, 1, 1);
    evict_vld = 1; evict_set = 9; evict_way = 1;
    close_win("same-cycle R9", 1, 1, 0);
    @(negedge clk);
    close_win("after close R8", 0, 0, 0);

    // R7: miss counter saturation
    @(negedge clk);
    miss_vld = 1;
    repeat (65540) @(negedge clk);
    miss_vld = 0;
    close_win("saturate R7", 0, 0, 65535);

    // R10: reset clears line marks
    ev(0, 10, 0, 1);
    rst_n = 0;
    repeat (2) @(negedge clk);
    check("R10 outputs cleared", miss_o, 0);
    rst_n = 1;
    @(negedge clk);
    ev(1, 10, 0, 0);
    close_win("reset marks R10", 0, 0, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule